// File: doc/BRIEF.md
# Multi-Port SPI Register Access Slave

This block is an SPI mode-0 target (clock idles low, data captured on the rising edge, changed on the falling edge) that gives a host byte-wide access to up to four identical per-port register windows of 32 locations each. A transaction begins when chip select goes low. The first byte is a header that holds a write flag, a port number and a register offset. Every later byte in the same selection writes to or reads from that location, and the offset then steps to the next register in the same window.

Each window holds a small stand-in for a serial port. It has a transmit strobe, a receive FIFO that a read drains, sticky event-status bytes that a read clears, a few read-only status locations and plain storage. The last location of every window maps to one shared global register. A read of it returns an active-low service-request summary with one bit per port. A write to it takes a command byte that switches an extended view on or off, and in that view offset 0x05 returns a fixed identity byte.

The SPI pins are sampled by the fast system clock, so SCLK must run at no more than one eighth of the system clock rate.

Top module: `spi_portreg_slave`

## Requirements
- R1: The header byte is decoded as follows. Bit 7 = 1 marks a write and 0 marks a read. Bits 6:5 give the port number. Bits 4:0 give the register offset.
- R2: MOSI is sampled on SCLK rising edges, MSB first. MISO changes only after SCLK falling edges. The first read byte appears on the falling edge that follows the eighth header bit. MISO is 0 while chip select is high. Raising chip select part-way through a byte discards that byte, and the next selection starts with a fresh header.
- R3: Each data byte after the header uses the current offset, and the offset then increments modulo 32 inside the same port window, so 0x1F is followed by 0x00.
- R4: A data byte written to offset 0x00 produces a one-cycle `tx_valid` pulse carrying that port number and byte. Nothing is stored.
- R5: A read of offset 0x00 returns the oldest entry of that port's receive FIFO and removes it. An empty FIFO reads 0x00. A byte pushed into a full FIFO is dropped. Offset 0x12 reads the entry count. A byte is removed only once the host clocks its first bit, so a peek after the last byte of a transaction removes nothing.
- R6: Reading offset 0x02 (event status), 0x06 (special status) or 0x08 (misc status) returns the bits collected from the matching event input and clears the bits returned.
- R7: Writes to offsets 0x02, 0x04, 0x06, 0x08, 0x11 and 0x12 have no effect. Offset 0x04 reads the port's `ln_sts` byte, and offset 0x11 reads 0x00.
- R8: All remaining offsets except 0x1F are plain read/write bytes, and each port keeps its own copy.
- R9: Offset 0x1F of any window reads the global summary. Bit n is 0 exactly when port n has a bit set in both its event status (0x02) and its enable byte (0x01). Bits above the port count read 1.
- R10: Writing 0xCE to offset 0x1F turns the extended view on, and writing 0xCD turns it off. Any other value leaves the view unchanged. While the view is on, offset 0x05 of every port reads REV_ID (default 0xB0). Writes to 0x05 still update the stored byte, which reads back once the view is off.
- R11: After reset, every register reads 0x00, the FIFOs are empty, the extended view is off and the global register reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| ev_irq | input | NPORTS*8 | Per-port event bits, ORed into offset 0x02 each cycle |
| ev_spc | input | NPORTS*8 | Per-port event bits, ORed into offset 0x06 each cycle |
| ev_sts | input | NPORTS*8 | Per-port event bits, ORed into offset 0x08 each cycle |
| ln_sts | input | NPORTS*8 | Per-port live status byte read at offset 0x04 |
| rx_push | input | 1 | Push `rx_data` into the FIFO of `rx_port` |
| rx_port | input | 2 | Target port of a push |
| rx_data | input | 8 | Byte to push |
| tx_valid | output | 1 | One-cycle strobe for a byte written to offset 0x00 |
| tx_port | output | 2 | Port of the strobed byte |
| tx_data | output | 8 | Strobed byte |

## Verification
Transactions are driven as single-byte and burst accesses over several ports. A burst that starts near the top of a window shows whether the offset wraps and whether the global alias sits at 0x1F in the middle of a stream. Receive reads are tried on an empty FIFO, on a partly filled FIFO and on an overfilled one, and are mixed into bursts that begin at other offsets, which shows whether a trailing peek wrongly removes a byte. Event pulses on different ports, combined with enable settings, separate the global summary from the clear-on-read behaviour. Aborted headers and aborted data bytes confirm that a partial byte never lands in a register.

// File: rtl/spi_portreg_slave.sv
module spi_portreg_slave #(
  parameter int NPORTS = 4,
  parameter int FIFO_DEPTH = 8,
  parameter logic [7:0] REV_ID = 8'hB0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                mosi,
  output logic                miso,
  input  logic [NPORTS*8-1:0] ev_irq,
  input  logic [NPORTS*8-1:0] ev_spc,
  input  logic [NPORTS*8-1:0] ev_sts,
  input  logic [NPORTS*8-1:0] ln_sts,
  input  logic                rx_push,
  input  logic [1:0]          rx_port,
  input  logic [7:0]          rx_data,
  output logic                tx_valid,
  output logic [1:0]          tx_port,
  output logic [7:0]          tx_data
);
  localparam int FW = $clog2(FIFO_DEPTH);
  localparam int CW = FW + 1;
  localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);
  localparam logic [2:0] NP = 3'(NPORTS);
  localparam logic [4:0] O_XH = 5'h00, O_IEN = 5'h01, O_IST = 5'h02, O_LST = 5'h04,
                         O_SEN = 5'h05, O_SST = 5'h06, O_EST = 5'h08, O_TXL = 5'h11,
                         O_RXL = 5'h12, O_GLB = 5'h1F;
  localparam logic [7:0] CMD_ON = 8'hCE, CMD_OFF = 8'hCD;

  logic [2:0] sck_q, mosi_q, csn_q;
  logic [2:0] bcnt;
  logic       got_addr, wr_mode, load_req, commit_pend, ext_on;
  logic [1:0] cur_port;
  logic [4:0] cur_off;
  logic [6:0] sh_in;
  logic [7:0] sh_out, snap, rd_val;

  logic [7:0]    rf    [NPORTS][32];
  logic [7:0]    st_irq[NPORTS];
  logic [7:0]    st_spc[NPORTS];
  logic [7:0]    st_sts[NPORTS];
  logic [7:0]    fmem  [NPORTS][FIFO_DEPTH];
  logic [FW-1:0] wp    [NPORTS];
  logic [FW-1:0] rp    [NPORTS];
  logic [CW-1:0] fcnt  [NPORTS];
  logic [NPORTS-1:0] pend, sel_p, push_p, pop_p;

  wire act       = ~csn_q[1];
  wire rise      = act & sck_q[1] & ~sck_q[2];
  wire fall      = act & ~sck_q[1] & sck_q[2];
  wire [7:0] byte_in = {sh_in, mosi_q[1]};
  wire byte_done = rise & (bcnt == 3'd7);
  wire port_ok   = {1'b0, cur_port} < NP;
  wire [1:0] pidx = port_ok ? cur_port : 2'd0;
  wire commit    = rise & commit_pend;
  wire [7:0] clr_mask = commit ? snap : 8'h00;
  wire wr_fire   = byte_done & got_addr & wr_mode;
  wire wr_glob   = wr_fire & (cur_off == O_GLB);
  wire ro_off    = (cur_off == O_IST) | (cur_off == O_LST) | (cur_off == O_SST) |
                   (cur_off == O_EST) | (cur_off == O_TXL) | (cur_off == O_RXL);
  wire wr_rf     = wr_fire & port_ok & ~ro_off & (cur_off != O_XH) & (cur_off != O_GLB);
  wire tx_fire   = wr_fire & port_ok & (cur_off == O_XH);
  wire [7:0] glob = ~{{(8-NPORTS){1'b0}}, pend};

  assign miso = act & sh_out[7];

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      pend[p]   = |(st_irq[p] & rf[p][O_IEN]);
      sel_p[p]  = port_ok && (pidx == 2'(p));
      push_p[p] = rx_push && (rx_port == 2'(p)) && (fcnt[p] != FULL);
      pop_p[p]  = commit && sel_p[p] && (cur_off == O_XH) && (fcnt[p] != '0);
    end
  end

  always_comb begin
    if (cur_off == O_GLB) rd_val = glob;
    else if (!port_ok)    rd_val = 8'h00;
    else begin
      case (cur_off)
        O_XH:    rd_val = (fcnt[pidx] != '0) ? fmem[pidx][rp[pidx]] : 8'h00;
        O_IST:   rd_val = st_irq[pidx];
        O_LST:   rd_val = ln_sts[{pidx, 3'b000} +: 8];
        O_SEN:   rd_val = ext_on ? REV_ID : rf[pidx][O_SEN];
        O_SST:   rd_val = st_spc[pidx];
        O_EST:   rd_val = st_sts[pidx];
        O_TXL:   rd_val = 8'h00;
        O_RXL:   rd_val = 8'(fcnt[pidx]);
        default: rd_val = rf[pidx][cur_off];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0; mosi_q <= '0; csn_q <= '1;
      bcnt <= '0; got_addr <= 1'b0; wr_mode <= 1'b0; load_req <= 1'b0;
      commit_pend <= 1'b0; cur_port <= '0; cur_off <= '0;
      sh_in <= '0; sh_out <= '0; snap <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sclk};
      mosi_q <= {mosi_q[1:0], mosi};
      csn_q  <= {csn_q[1:0], cs_n};
      if (!act) begin
        bcnt <= '0; got_addr <= 1'b0; load_req <= 1'b0;
        commit_pend <= 1'b0; sh_out <= '0;
      end else if (rise) begin
        sh_in <= byte_in[6:0];
        bcnt  <= bcnt + 3'd1;
        commit_pend <= 1'b0;
        if (bcnt == 3'd7) begin
          if (!got_addr) begin
            got_addr <= 1'b1;
            wr_mode  <= byte_in[7];
            cur_port <= byte_in[6:5];
            cur_off  <= byte_in[4:0];
            load_req <= ~byte_in[7];
          end else begin
            cur_off  <= cur_off + 5'd1;
            load_req <= ~wr_mode;
          end
        end
      end else if (fall) begin
        if (load_req) begin
          sh_out <= rd_val; snap <= rd_val;
          load_req <= 1'b0; commit_pend <= 1'b1;
        end else begin
          sh_out <= {sh_out[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_on <= 1'b0; tx_valid <= 1'b0; tx_port <= '0; tx_data <= '0;
      for (int p = 0; p < NPORTS; p++) begin
        st_irq[p] <= '0; st_spc[p] <= '0; st_sts[p] <= '0;
        wp[p] <= '0; rp[p] <= '0; fcnt[p] <= '0;
        for (int r = 0; r < 32; r++) rf[p][r] <= '0;
      end
    end else begin
      tx_valid <= tx_fire;
      if (tx_fire) begin
        tx_port <= cur_port;
        tx_data <= byte_in;
      end
      if (wr_glob && byte_in == CMD_ON)  ext_on <= 1'b1;
      if (wr_glob && byte_in == CMD_OFF) ext_on <= 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
        st_irq[p] <= (st_irq[p] & ~((sel_p[p] && cur_off == O_IST) ? clr_mask : 8'h00)) | ev_irq[p*8 +: 8];
        st_spc[p] <= (st_spc[p] & ~((sel_p[p] && cur_off == O_SST) ? clr_mask : 8'h00)) | ev_spc[p*8 +: 8];
        st_sts[p] <= (st_sts[p] & ~((sel_p[p] && cur_off == O_EST) ? clr_mask : 8'h00)) | ev_sts[p*8 +: 8];
        if (push_p[p]) wp[p] <= wp[p] + FW'(1);
        if (pop_p[p])  rp[p] <= rp[p] + FW'(1);
        fcnt[p] <= fcnt[p] + CW'(push_p[p]) - CW'(pop_p[p]);
        if (wr_rf && sel_p[p]) rf[p][cur_off] <= byte_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORTS; p++)
      if (push_p[p]) fmem[p][wp[p]] <= rx_data;
  end
endmodule

// File: rtl/spi_portreg_slave_chk.sv
module spi_portreg_slave_chk #(
  parameter int NPORTS = 4,
  parameter int FIFO_DEPTH = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         miso,
  input logic                         act,
  input logic                         sck_hi,
  input logic                         tx_valid,
  input logic                         ext_on,
  input logic                         wr_glob,
  input logic [$clog2(FIFO_DEPTH):0]  fcnt [NPORTS]
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  assert_tx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);

  assert_miso_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(act) && act && $past(sck_hi)) |-> $stable(miso));

  assert_ext_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_on != $past(ext_on)) |-> $past(wr_glob));

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fcnt[g] <= CW'(FIFO_DEPTH));
    assert_fifo_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fcnt[g] != $past(fcnt[g])) |->
        ((fcnt[g] == $past(fcnt[g]) + CW'(1)) || (fcnt[g] + CW'(1) == $past(fcnt[g]))));
  end
endmodule

bind spi_portreg_slave spi_portreg_slave_chk #(.NPORTS(NPORTS), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .miso(miso), .act(act), .sck_hi(sck_q[1]),
  .tx_valid(tx_valid), .ext_on(ext_on), .wr_glob(wr_glob), .fcnt(fcnt)
);

// File: tb/spi_portreg_slave_bench.sv
module spi_portreg_slave_bench;
  localparam int HALF = 8;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, rx_push = 0, tx_valid;
  logic [1:0] rx_port = 0, tx_port;
  logic [7:0] rx_data = 0, tx_data;
  logic [31:0] ev_irq = 0, ev_spc = 0, ev_sts = 0;
  logic [31:0] ln_sts = 32'h44_33_22_11;

  always #2 clk = ~clk;

  spi_portreg_slave u_spi_portreg_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .ev_irq(ev_irq), .ev_spc(ev_spc), .ev_sts(ev_sts), .ln_sts(ln_sts),
    .rx_push(rx_push), .rx_port(rx_port), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_port(tx_port), .tx_data(tx_data));

  int n_chk = 0, n_err = 0, csn_hi = 0;
  bit finished = 0;

  logic [7:0] m_rf [4][32];
  logic [7:0] m_fifo [4][$];
  logic [7:0] m_irq [4], m_spc [4], m_sts [4];
  bit         m_ext = 0;
  logic [9:0] exp_tx [$];
  logic [7:0] wbuf [8];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input int p, input int o);
    logic [7:0] v;
    case (o)
      31: begin
        v = 8'hFF;
        for (int q = 0; q < 4; q++) if ((m_irq[q] & m_rf[q][1]) != 0) v[q] = 1'b0;
      end
      0:  v = (m_fifo[p].size() > 0) ? m_fifo[p].pop_front() : 8'h00;
      2:  begin v = m_irq[p]; m_irq[p] = 0; end
      4:  v = ln_sts[p*8 +: 8];
      5:  v = m_ext ? 8'hB0 : m_rf[p][5];
      6:  begin v = m_spc[p]; m_spc[p] = 0; end
      8:  begin v = m_sts[p]; m_sts[p] = 0; end
      17: v = 8'h00;
      18: v = 8'(m_fifo[p].size());
      default: v = m_rf[p][o];
    endcase
    return v;
  endfunction

  function automatic void m_write(input int p, input int o, input logic [7:0] d);
    if (o == 31) begin
      if (d == 8'hCE) m_ext = 1;
      if (d == 8'hCD) m_ext = 0;
    end else if (o == 0) exp_tx.push_back({2'(p), d});
    else if (!(o inside {2, 4, 6, 8, 17, 18})) m_rf[p][o] = d;
  endfunction

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 0;
    for (int b = 7; b > 7 - nb; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
  endtask

  task automatic spi_read(input int p, input int o, input int n, input string req);
    logic [7:0] r;
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    spi_bits({1'b0, 2'(p), 5'(o)}, 8, r);
    for (int i = 0; i < n; i++) begin
      spi_bits(8'h00, 8, r);
      check(req, r, m_read(p, (o + i) % 32));
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic spi_write(input int p, input int o, input int n);
    logic [7:0] r;
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    spi_bits({1'b1, 2'(p), 5'(o)}, 8, r);
    for (int i = 0; i < n; i++) begin
      m_write(p, (o + i) % 32, wbuf[i]);
      spi_bits(wbuf[i], 8, r);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic spi_abort(input logic [7:0] hdr, input int hbits, input int dbits);
    logic [7:0] r;
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    spi_bits(hdr, hbits, r);
    if (dbits > 0) spi_bits(8'hA5, dbits, r);
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic push(input int p, input logic [7:0] d);
    @(negedge clk);
    rx_push = 1; rx_port = 2'(p); rx_data = d;
    if (m_fifo[p].size() < 8) m_fifo[p].push_back(d);
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic pulse_ev(input int p, input logic [7:0] i, input logic [7:0] s, input logic [7:0] t);
    @(negedge clk);
    ev_irq[p*8 +: 8] = i; ev_spc[p*8 +: 8] = s; ev_sts[p*8 +: 8] = t;
    m_irq[p] |= i; m_spc[p] |= s; m_sts[p] |= t;
    @(negedge clk);
    ev_irq = 0; ev_spc = 0; ev_sts = 0;
  endtask

  // every clock: tx strobes against the model queue, idle MISO level
  always @(negedge clk) begin
    csn_hi = cs_n ? csn_hi + 1 : 0;
    if (rst_n && !finished) begin
      if (csn_hi >= 4) check("R2 idle miso", {7'd0, miso}, 8'h00);
      if (tx_valid) begin
        if (exp_tx.size() == 0) check("R4 unexpected tx", {6'd0, tx_port}, 8'hFF);
        else begin
          logic [9:0] e;
          e = exp_tx.pop_front();
          check("R4 tx port", {6'd0, tx_port}, {6'd0, e[9:8]});
          check("R4 tx data", tx_data, e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      m_irq[p] = 0; m_spc[p] = 0; m_sts[p] = 0;
      for (int r = 0; r < 32; r++) m_rf[p][r] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R11 reset state
    spi_read(0, 31, 1, "R11 global");
    spi_read(0, 1, 1, "R11 enable");
    spi_read(0, 18, 1, "R11 fifo count");
    spi_read(3, 9, 2, "R11 storage");

    // R8 R3 R1 burst storage per port
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    spi_write(1, 9, 3);
    spi_read(1, 9, 3, "R8 readback");
    spi_read(2, 9, 3, "R8 other port");

    // R3 wrap through global into offset 0
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'h00; wbuf[3] = 8'hA4;
    spi_write(2, 29, 4);
    spi_read(2, 29, 2, "R3 wrap storage");

    // R4 R7 tx strobe, then enable, then read-only status
    wbuf[0] = 8'h5A; wbuf[1] = 8'h04; wbuf[2] = 8'hFF;
    spi_write(3, 0, 3);
    spi_read(3, 1, 2, "R7 ro after burst");

    // R7 read-only locations
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    spi_write(0, 17, 2);
    spi_write(0, 4, 1);
    spi_read(0, 4, 1, "R7 line status");
    spi_read(0, 17, 2, "R7 levels");

    // R5 receive FIFO
    push(2, 8'h10); push(2, 8'h20); push(2, 8'h30);
    spi_read(2, 18, 1, "R5 count");
    spi_read(2, 0, 1, "R5 head");
    spi_read(2, 0, 2, "R5 head then enable");
    spi_read(2, 18, 1, "R5 count after peek");
    spi_read(2, 31, 2, "R5 global then head");
    spi_read(2, 0, 1, "R5 empty");
    for (int i = 0; i < 9; i++) push(0, 8'(i + 8'h40));
    spi_read(0, 18, 1, "R5 full count");
    spi_read(0, 0, 1, "R5 full head");

    // R6 R9 events
    wbuf[0] = 8'h04;
    spi_write(1, 1, 1);
    pulse_ev(1, 8'h05, 8'h00, 8'h00);
    pulse_ev(0, 8'h00, 8'h81, 8'h00);
    pulse_ev(3, 8'h08, 8'h00, 8'h20);
    spi_read(0, 31, 1, "R9 summary");
    spi_read(1, 2, 1, "R6 irq status");
    spi_read(1, 2, 1, "R6 irq cleared");
    spi_read(3, 31, 1, "R9 summary after clear");
    spi_read(0, 6, 1, "R6 special status");
    spi_read(0, 6, 1, "R6 special cleared");
    spi_read(3, 8, 1, "R6 misc status");
    spi_read(3, 2, 1, "R6 masked irq");

    // R10 extended view
    wbuf[0] = 8'h5A;
    spi_write(0, 5, 1);
    spi_read(0, 5, 1, "R10 normal view");
    wbuf[0] = 8'hCE;
    spi_write(2, 31, 1);
    spi_read(0, 5, 1, "R10 ext port0");
    spi_read(3, 5, 1, "R10 ext port3");
    wbuf[0] = 8'h77;
    spi_write(1, 31, 1);
    spi_read(1, 5, 1, "R10 other cmd");
    wbuf[0] = 8'h33;
    spi_write(0, 5, 1);
    wbuf[0] = 8'hCD;
    spi_write(0, 31, 1);
    spi_read(0, 5, 1, "R10 view off");

    // R2 aborted header and aborted data byte
    spi_abort(8'b1000_1100, 4, 0);
    spi_read(1, 9, 1, "R2 after aborted header");
    spi_abort(8'b1000_1100, 8, 4);
    spi_read(0, 12, 1, "R2 aborted data");

    repeat (20) @(negedge clk);
    check("R4 tx remaining", 8'(exp_tx.size()), 8'h00);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule